// File: doc/BRIEF.md
# Four-Way Tag Directory with Selectable Replacement

This block holds the tags and valid bits for a tiny set-associative cache of 128 bytes: 16-byte lines, 8 lines in all, arranged as 2 sets of 4 ways. Each request carries a 12-bit byte address. The block splits the address into tag, set and offset fields. It answers with hit or miss, the way that was hit or filled, and the tag of any valid line that the fill pushed out. On a miss it installs the new tag at once. Line data, word selection, refill traffic and writes belong to other blocks.

The victim is picked by one of two policies. True least-recently-used keeps a recency order in each set. Round-robin keeps a fill pointer in each set, and hits leave that pointer alone. The policy is sampled while reset is held, so switching it needs a reset. The block also counts all accesses and all misses, and both counts are visible on output ports.

Top module: `sa_tag_directory`

## Requirements
- R1: The address is decoded as offset = bits [3:0] (ignored), set = bit [4], tag = bits [11:5]. Two addresses that differ only in the offset refer to the same line.
- R2: After reset every way is invalid, both counters read 0 and rsp_valid is 0. The first access to any set misses.
- R3: A request whose tag matches a valid way of its set reports rsp_hit=1 and that way on rsp_way. It changes no tag.
- R4: While a set has invalid ways, a miss fills the lowest-numbered invalid way under either policy.
- R5: With LRU selected (policy_lru=1 during reset) and the set full, a miss replaces the least recently used way.
- R6: In LRU mode a hit or a fill makes the touched way most recent. Every way that was more recent than it moves one step older.
- R7: With FIFO selected (policy_lru=0 during reset) a full set is refilled round-robin by a per-set 2-bit pointer. The pointer advances by one (mod 4) on each miss only, and hits do not affect it.
- R8: evict_valid is 1 exactly when a miss replaces a valid line, and evict_tag then carries that line's old tag.
- R9: access_count rises by one for each accepted request.
- R10: miss_count rises by one for each request that misses.
- R11: Changes on policy_lru while rst_n is high have no effect until the next reset.
- R12: The response (rsp_valid and its fields) appears in the cycle after the request. rsp_valid is 0 in any cycle that follows a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; policy_lru is sampled while it is low |
| policy_lru | input | 1 | 1 = LRU replacement, 0 = round-robin replacement |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Byte address of the request |
| rsp_valid | output | 1 | Response present (one cycle after the request) |
| rsp_hit | output | 1 | 1 = hit, 0 = miss with fill |
| rsp_way | output | 2 | Way hit or filled |
| evict_valid | output | 1 | A valid line was replaced |
| evict_tag | output | 7 | Tag of the replaced line |
| access_count | output | 16 | Total requests since reset |
| miss_count | output | 16 | Total misses since reset |

## Verification
The bench replays a thirteen-address stream that contains set conflicts under both policies. It checks the totals: 8 misses with LRU and 9 with round-robin. A design that moved the round-robin pointer on hits, or that failed to refresh recency on a hit, lands on a different total and evicts the wrong tags. Filling an invalid way other than the lowest shows up as a wrong rsp_way during warm-up. Toggling the policy pin mid-run would change the round-robin total if the pin were obeyed outside reset. A long pseudo-random run over a few tags per set compares every response against a reference model.

// File: rtl/sa_tag_directory.sv
module sa_tag_directory #(
  parameter int ADDR_W = 12,
  parameter int OFFS_W = 4,
  parameter int SET_W  = 1,
  parameter int WAY_W  = 2,
  parameter int CNT_W  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           policy_lru,
  input  logic                           req_valid,
  input  logic [ADDR_W-1:0]              req_addr,
  output logic                           rsp_valid,
  output logic                           rsp_hit,
  output logic [WAY_W-1:0]               rsp_way,
  output logic                           evict_valid,
  output logic [ADDR_W-OFFS_W-SET_W-1:0] evict_tag,
  output logic [CNT_W-1:0]               access_count,
  output logic [CNT_W-1:0]               miss_count
);
  localparam int TAG_W = ADDR_W - OFFS_W - SET_W;
  localparam int SETS  = 1 << SET_W;
  localparam int WAYS  = 1 << WAY_W;

  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic             valid_q [SETS][WAYS];
  logic [WAY_W-1:0] age_q   [SETS][WAYS];
  logic [WAY_W-1:0] ptr_q   [SETS];
  logic             mode_q;

  logic [SET_W-1:0] req_set;
  logic [TAG_W-1:0] req_tag;
  logic [WAYS-1:0]  hit_vec;
  logic             hit;
  logic [WAY_W-1:0] hit_way, free_way, lru_way, victim, use_way;
  logic             free_any;
  logic             offs_unused;

  assign req_set     = req_addr[OFFS_W +: SET_W];
  assign req_tag     = req_addr[ADDR_W-1 -: TAG_W];
  assign offs_unused = ^req_addr[OFFS_W-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_q[req_set][w] && (tag_q[req_set][w] == req_tag);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    lru_way  = '0;
    free_any = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
      if (!valid_q[req_set][w]) begin
        free_way = WAY_W'(w);
        free_any = 1'b1;
      end
      if (age_q[req_set][w] == WAY_W'(WAYS - 1)) lru_way = WAY_W'(w);
    end
  end

  assign victim  = free_any ? free_way : (mode_q ? lru_way : ptr_q[req_set]);
  assign use_way = hit ? hit_way : victim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q       <= policy_lru;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_way      <= '0;
      evict_valid  <= 1'b0;
      evict_tag    <= '0;
      access_count <= '0;
      miss_count   <= '0;
      for (int s = 0; s < SETS; s++) begin
        ptr_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          tag_q[s][w]   <= '0;
          age_q[s][w]   <= WAY_W'(w);
        end
      end
    end else begin
      rsp_valid   <= req_valid;
      rsp_hit     <= hit;
      rsp_way     <= use_way;
      evict_valid <= req_valid && !hit && valid_q[req_set][victim];
      evict_tag   <= tag_q[req_set][victim];
      if (req_valid) begin
        access_count <= access_count + 1'b1;
        if (!hit) begin
          miss_count               <= miss_count + 1'b1;
          tag_q[req_set][victim]   <= req_tag;
          valid_q[req_set][victim] <= 1'b1;
          if (!mode_q) ptr_q[req_set] <= ptr_q[req_set] + 1'b1;
        end
        if (mode_q) begin
          for (int w = 0; w < WAYS; w++) begin
            if (WAY_W'(w) == use_way)
              age_q[req_set][w] <= '0;
            else if (age_q[req_set][w] < age_q[req_set][use_way])
              age_q[req_set][w] <= age_q[req_set][w] + 1'b1;
          end
        end
      end
    end
  end

  AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R3
  AST_HIT_NO_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> !evict_valid); // R8
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid == $past(req_valid)); // R12
  AST_ACCESS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid) |-> access_count == $past(access_count) + 1'b1); // R9
  AST_ACCESS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(req_valid) |-> $stable(access_count)); // R9
  AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> miss_count == $past(miss_count) + 1'b1); // R10
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(mode_q)); // R11
  always @(posedge clk)
    if (rst_n) AST_MISS_LE_ACCESS: assert (miss_count <= access_count); // R10
endmodule

// File: tb/sa_tag_directory_bench.sv
module sa_tag_directory_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        policy_lru = 1'b1;
  logic        req_valid = 1'b0;
  logic [11:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, evict_valid;
  logic [1:0]  rsp_way;
  logic [6:0]  evict_tag;
  logic [15:0] access_count, miss_count;

  always #2 clk = ~clk;

  sa_tag_directory u_sa_tag_directory (
    .clk(clk), .rst_n(rst_n), .policy_lru(policy_lru), .req_valid(req_valid),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .evict_valid(evict_valid), .evict_tag(evict_tag),
    .access_count(access_count), .miss_count(miss_count));

  typedef struct packed {
    logic       hit;
    logic [1:0] way;
    logic       ev;
    logic [6:0] etag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;

  logic [6:0] m_tag [2][4];
  logic       m_val [2][4];
  int         m_age [2][4];
  logic [1:0] m_ptr [2];
  logic       m_lru;
  int         m_acc, m_miss;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic lru);
    @(negedge clk);
    req_valid  = 1'b0;
    policy_lru = lru;
    rst_n      = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_lru = lru;
    m_acc = 0;
    m_miss = 0;
    for (int s = 0; s < 2; s++) begin
      m_ptr[s] = 0;
      for (int w = 0; w < 4; w++) begin
        m_val[s][w] = 0; m_tag[s][w] = 0; m_age[s][w] = w;
      end
    end
    chk("R2 rsp_valid after reset", rsp_valid, 0);
    chk("R2 access_count after reset", access_count, 0);
    chk("R2 miss_count after reset", miss_count, 0);
  endtask

  task automatic access(input logic [11:0] a);
    int   s, use_w, victim;
    logic [6:0] t;
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    s = a[4];
    t = a[11:5];
    use_w = -1;
    for (int w = 0; w < 4; w++) if (m_val[s][w] && m_tag[s][w] == t) use_w = w;
    e = '0;
    m_acc++;
    if (use_w >= 0) begin
      e.hit = 1'b1;
    end else begin
      victim = -1;
      for (int w = 3; w >= 0; w--) if (!m_val[s][w]) victim = w;
      if (victim < 0) begin
        if (m_lru) begin
          for (int w = 0; w < 4; w++) if (m_age[s][w] == 3) victim = w;
        end else victim = m_ptr[s];
        e.ev   = 1'b1;
        e.etag = m_tag[s][victim];
      end
      use_w = victim;
      m_tag[s][victim] = t;
      m_val[s][victim] = 1'b1;
      m_miss++;
      if (!m_lru) m_ptr[s] = m_ptr[s] + 2'd1;
    end
    e.way = use_w[1:0];
    if (m_lru) begin
      for (int w = 0; w < 4; w++)
        if (w != use_w && m_age[s][w] < m_age[s][use_w]) m_age[s][w]++;
      m_age[s][use_w] = 0;
    end
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      if (exp_q.size() == 0) begin
        chk("R12 unexpected response", 1, 0);
      end else begin
        e = exp_q.pop_front();
        chk("R3 hit flag", rsp_hit, e.hit);
        chk("R4/R5/R7 way", rsp_way, e.way);
        chk("R8 evict_valid", evict_valid, e.ev);
        if (e.ev) chk("R8 evict_tag", evict_tag, e.etag);
      end
    end
  end

  logic [11:0] stream [13] = '{12'h110, 12'h136, 12'h202, 12'h1A3, 12'h102, 12'h361,
                               12'h204, 12'h114, 12'h1A4, 12'h177, 12'h301, 12'h206, 12'h135};

  initial begin
    #300000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    foreach (stream[i]) access(stream[i]);
    idle(2);
    chk("R5 R6 R10 LRU miss total", miss_count, 8);
    chk("R9 access total", access_count, 13);
    chk("R12 rsp idle", rsp_valid, 0);

    do_reset(1'b0);
    access(12'h110);
    access(12'h11F);
    idle(2);
    chk("R1 offset ignored miss_count", miss_count, 1);
    policy_lru = 1'b1;
    do_reset(1'b0);
    policy_lru = 1'b1;
    foreach (stream[i]) access(stream[i]);
    idle(2);
    chk("R7 R11 FIFO miss total", miss_count, 9);
    chk("R9 access total fifo", access_count, 13);

    for (int mode = 0; mode < 2; mode++) begin
      do_reset(mode[0]);
      for (int i = 0; i < 400; i++) begin
        logic [11:0] a;
        a = {4'd0, 3'($urandom % 6), 1'($urandom), 4'($urandom)};
        access(a);
        if ($urandom % 4 == 0) idle(1);
      end
      idle(2);
      chk("R9 random access total", access_count, m_acc);
      chk("R10 random miss total", miss_count, m_miss);
      chk("R12 queue drained", exp_q.size(), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule